// File: doc/BRIEF.md
# Dual-Edge Input Capture Register

This block samples a parallel data bus on both the rising and the falling edge of its clock. It hands the pair of samples to single-rate logic as two buses that both update on the rising edge: one carries the sample that comes first in each pair, the other carries the sample that comes second. A build parameter chooses which clock edge opens a pair.

Each capture register can take an asynchronous control, set at build time to clear, to preset, or to no async control at all. With no async control, a parameter sets the power-up level. Synchronous clear and preset inputs act on each register's own capture edge. A clock enable freezes every register. The falling-edge sample is re-registered on the next rising edge, so downstream logic sees a single clock domain.

Top module: `ddr_capture`

## Requirements
- R1: `din_i` is sampled on both clock edges, and every sample accepted while enabled reaches exactly one of the two output buses.
- R2: With `FIRST_ON_RISE`=1, the value on `din_i` at rising edge k appears on `first_o`, and the value at the falling edge after it appears on `second_o`. Both become visible after rising edge k+1.
- R3: With `FIRST_ON_RISE`=0, the value on `din_i` at the falling edge before rising edge k appears on `first_o`, and the value at rising edge k appears on `second_o`. Both become visible after rising edge k.
- R4: With `ASYNC_KIND`=ASYNC_CLEAR (code 1), a high level on `arst_i` drives every register and both outputs to all zeros at once, without waiting for a clock edge. The registers stay there while `arst_i` is high.
- R5: With `ASYNC_KIND`=ASYNC_PRESET (code 2), a high level on `arst_i` drives every register and both outputs to all ones at once. The registers stay there while `arst_i` is high.
- R6: With `ASYNC_KIND`=ASYNC_NONE (code 0), every register starts at all ones if `POWERUP_HIGH`=1 and at all zeros otherwise, and `arst_i` has no effect on the outputs.
- R7: `sclr_i` high at a capture edge loads zeros into the registers clocked by that edge. After a rising edge with `sclr_i` high, both outputs are zero.
- R8: `sset_i` high with `sclr_i` low loads ones into the registers clocked by that edge. After a rising edge where this holds, both outputs are all ones.
- R9: When `sclr_i` and `sset_i` are both high, the clear wins.
- R10: `en_i` low, with both synchronous controls low, makes every register keep its value, so neither output changes. Either synchronous control acts whatever the level of `en_i`.
- R11: Outside of asynchronous control, the outputs change only on rising clock edges, and they hold across the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Capture clock; both edges are used |
| arst_i | input | 1 | Asynchronous control, active high; clear or preset as set by `ASYNC_KIND` |
| en_i | input | 1 | Clock enable, active high |
| sclr_i | input | 1 | Synchronous clear, active high |
| sset_i | input | 1 | Synchronous preset, active high |
| din_i | input | WIDTH | Double-rate data input |
| first_o | output | WIDTH | Sample that opens each pair, rising-edge aligned |
| second_o | output | WIDTH | Sample that closes each pair, rising-edge aligned |

## Verification
The bench builds three copies side by side on shared stimulus, all 8 bits wide. The first copy opens pairs on the rising edge and uses an async clear. The second opens pairs on the falling edge and uses an async preset. The third has no async control and powers up high. Because the copies run together, both pair orderings, both async flavours and the ignored async input can be compared on the same data, and the power-up level can be seen before the first enabled edge.

// File: rtl/ddr_capture_pkg.sv
`timescale 1ns/1ps
package ddr_capture_pkg;

  typedef enum logic [1:0] {
    ASYNC_NONE   = 2'd0,
    ASYNC_CLEAR  = 2'd1,
    ASYNC_PRESET = 2'd2
  } async_kind_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_ZERO = 2'd2,
    ACT_ONE  = 2'd3
  } reg_action_e;

  // Clear beats preset, and both beat the enable.
  function automatic reg_action_e next_action(input logic sclr, input logic sset,
                                              input logic en);
    if (sclr)      return ACT_ZERO;
    else if (sset) return ACT_ONE;
    else if (en)   return ACT_LOAD;
    else           return ACT_HOLD;
  endfunction

endpackage

// File: rtl/ddr_edge_reg.sv
`timescale 1ns/1ps
module ddr_edge_reg
  import ddr_capture_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter bit          ON_FALL   = 1'b0,
  parameter async_kind_e AK        = ASYNC_CLEAR,
  parameter bit          INIT_HIGH = 1'b0
) (
  input  logic         clk_i,
  input  logic         arst_i,
  input  logic         en_i,
  input  logic         sclr_i,
  input  logic         sset_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam bit          HAS_ASYNC = (AK != ASYNC_NONE);
  localparam logic [W-1:0] ASYNC_VAL = (AK == ASYNC_PRESET) ? {W{1'b1}} : {W{1'b0}};
  localparam logic [W-1:0] START_VAL = HAS_ASYNC ? ASYNC_VAL : {W{INIT_HIGH}};

  logic [W-1:0] q_r = START_VAL;
  logic [W-1:0] nxt;

  always_comb begin
    unique case (next_action(sclr_i, sset_i, en_i))
      ACT_ZERO: nxt = {W{1'b0}};
      ACT_ONE:  nxt = {W{1'b1}};
      ACT_LOAD: nxt = d_i;
      default:  nxt = q_r;
    endcase
  end

  generate
    if (HAS_ASYNC && ON_FALL) begin : g_async_fall
      always_ff @(negedge clk_i or posedge arst_i) begin
        if (arst_i) q_r <= ASYNC_VAL;
        else        q_r <= nxt;
      end
    end else if (HAS_ASYNC) begin : g_async_rise
      always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) q_r <= ASYNC_VAL;
        else        q_r <= nxt;
      end
    end else if (ON_FALL) begin : g_plain_fall
      always_ff @(negedge clk_i) q_r <= nxt;
    end else begin : g_plain_rise
      always_ff @(posedge clk_i) q_r <= nxt;
    end
  endgenerate

  assign q_o = q_r;

endmodule

// File: rtl/ddr_capture.sv
`timescale 1ns/1ps
module ddr_capture
  import ddr_capture_pkg::*;
#(
  parameter int unsigned WIDTH         = 8,
  parameter bit          FIRST_ON_RISE = 1'b1,
  parameter async_kind_e ASYNC_KIND    = ASYNC_CLEAR,
  parameter bit          POWERUP_HIGH  = 1'b0,
  parameter bit          HAS_SYNC      = 1'b1,
  parameter bit          HAS_ENABLE    = 1'b1
) (
  input  logic             clk_i,
  input  logic             arst_i,
  input  logic             en_i,
  input  logic             sclr_i,
  input  logic             sset_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] first_o,
  output logic [WIDTH-1:0] second_o
);

  // Controls after the build options are applied; named for the checker.
  logic en_eff, sclr_eff, sset_eff;
  assign en_eff   = HAS_ENABLE ? en_i   : 1'b1;
  assign sclr_eff = HAS_SYNC   ? sclr_i : 1'b0;
  assign sset_eff = HAS_SYNC   ? sset_i : 1'b0;

  logic [WIDTH-1:0] rise_q;     // sample taken on the rising edge
  logic [WIDTH-1:0] fall_q;     // sample taken on the falling edge
  logic [WIDTH-1:0] fall_al_q;  // falling sample moved to the rising domain

  ddr_edge_reg #(.W(WIDTH), .ON_FALL(1'b0), .AK(ASYNC_KIND), .INIT_HIGH(POWERUP_HIGH))
    u_rise (.clk_i(clk_i), .arst_i(arst_i), .en_i(en_eff), .sclr_i(sclr_eff),
            .sset_i(sset_eff), .d_i(din_i), .q_o(rise_q));

  ddr_edge_reg #(.W(WIDTH), .ON_FALL(1'b1), .AK(ASYNC_KIND), .INIT_HIGH(POWERUP_HIGH))
    u_fall (.clk_i(clk_i), .arst_i(arst_i), .en_i(en_eff), .sclr_i(sclr_eff),
            .sset_i(sset_eff), .d_i(din_i), .q_o(fall_q));

  ddr_edge_reg #(.W(WIDTH), .ON_FALL(1'b0), .AK(ASYNC_KIND), .INIT_HIGH(POWERUP_HIGH))
    u_fall_al (.clk_i(clk_i), .arst_i(arst_i), .en_i(en_eff), .sclr_i(sclr_eff),
               .sset_i(sset_eff), .d_i(fall_q), .q_o(fall_al_q));

  generate
    if (FIRST_ON_RISE) begin : g_rise_first
      // The rising sample opens the pair, so it waits one cycle for its partner.
      logic [WIDTH-1:0] rise_dly_q;
      ddr_edge_reg #(.W(WIDTH), .ON_FALL(1'b0), .AK(ASYNC_KIND), .INIT_HIGH(POWERUP_HIGH))
        u_rise_dly (.clk_i(clk_i), .arst_i(arst_i), .en_i(en_eff), .sclr_i(sclr_eff),
                    .sset_i(sset_eff), .d_i(rise_q), .q_o(rise_dly_q));
      assign first_o  = rise_dly_q;
      assign second_o = fall_al_q;
    end else begin : g_fall_first
      assign first_o  = fall_al_q;
      assign second_o = rise_q;
    end
  endgenerate

endmodule

// File: rtl/ddr_capture_chk.sv
`timescale 1ns/1ps
module ddr_capture_chk
  import ddr_capture_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter async_kind_e AK = ASYNC_CLEAR
) (
  input logic         clk_i,
  input logic         arst_i,
  input logic         en_i,
  input logic         sclr_i,
  input logic         sset_i,
  input logic [W-1:0] first_i,
  input logic [W-1:0] second_i
);

  logic arst_act;
  assign arst_act = (AK != ASYNC_NONE) && arst_i;

  generate
    if (AK == ASYNC_CLEAR) begin : g_clr
      // R4
      async_clear_chk: assert property (@(posedge clk_i)
        arst_i |-> (first_i == '0 && second_i == '0));
    end else if (AK == ASYNC_PRESET) begin : g_set
      // R5
      async_preset_chk: assert property (@(posedge clk_i)
        arst_i |-> (first_i == '1 && second_i == '1));
    end
  endgenerate

  // R7
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (arst_act)
    sclr_i |=> (first_i == '0 && second_i == '0));

  // R8
  sync_preset_chk: assert property (@(posedge clk_i) disable iff (arst_act)
    (sset_i && !sclr_i) |=> (first_i == '1 && second_i == '1));

  // R9
  sync_priority_chk: assert property (@(posedge clk_i) disable iff (arst_act)
    (sclr_i && sset_i) |=> (first_i != '1 && second_i != '1));

  // R10
  enable_hold_chk: assert property (@(posedge clk_i) disable iff (arst_act)
    (!en_i && !sclr_i && !sset_i) |=> ($stable(first_i) && $stable(second_i)));

endmodule

bind ddr_capture ddr_capture_chk #(.W(WIDTH), .AK(ASYNC_KIND)) u_chk (
  .clk_i(clk_i), .arst_i(arst_i), .en_i(en_eff), .sclr_i(sclr_eff),
  .sset_i(sset_eff), .first_i(first_o), .second_i(second_o));

// File: tb/ddr_capture_bench.sv
`timescale 1ns/1ps
module ddr_capture_bench;
  import ddr_capture_pkg::*;

  logic       clk  = 1'b0;
  logic       arst = 1'b1;
  logic       en   = 1'b0;
  logic       sclr = 1'b0;
  logic       sset = 1'b0;
  logic [7:0] din  = 8'h00;
  string      tag  = "R1 R2 R3";

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] act_first [3];
  logic [7:0] act_second[3];

  always #4 clk = ~clk;  // 125 MHz

  ddr_capture #(.WIDTH(8), .FIRST_ON_RISE(1'b1), .ASYNC_KIND(ASYNC_CLEAR))
    u_ddr_capture (.clk_i(clk), .arst_i(arst), .en_i(en), .sclr_i(sclr), .sset_i(sset),
                   .din_i(din), .first_o(act_first[0]), .second_o(act_second[0]));

  ddr_capture #(.WIDTH(8), .FIRST_ON_RISE(1'b0), .ASYNC_KIND(ASYNC_PRESET))
    u_ddr_capture_fe (.clk_i(clk), .arst_i(arst), .en_i(en), .sclr_i(sclr), .sset_i(sset),
                      .din_i(din), .first_o(act_first[1]), .second_o(act_second[1]));

  ddr_capture #(.WIDTH(8), .FIRST_ON_RISE(1'b1), .ASYNC_KIND(ASYNC_NONE), .POWERUP_HIGH(1'b1))
    u_ddr_capture_pu (.clk_i(clk), .arst_i(arst), .en_i(en), .sclr_i(sclr), .sset_i(sset),
                      .din_i(din), .first_o(act_first[2]), .second_o(act_second[2]));

  // Reference model: per copy, the last accepted sample of each edge and the pair shown.
  localparam bit RISE_FIRST[3] = '{1'b1, 1'b0, 1'b1};
  logic [7:0] last_fall[3] = '{8'h00, 8'hFF, 8'hFF};
  logic [7:0] last_rise[3] = '{8'h00, 8'hFF, 8'hFF};
  logic [7:0] exp_first[3] = '{8'h00, 8'hFF, 8'hFF};
  logic [7:0] exp_second[3] = '{8'h00, 8'hFF, 8'hFF};

  function automatic logic [7:0] upd(input logic [7:0] cur, input logic [7:0] cand);
    if (sclr) return 8'h00;
    if (sset) return 8'hFF;
    if (en)   return cand;
    return cur;
  endfunction

  function automatic logic [7:0] forced(input int idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction

  task automatic force_async();
    for (int i = 0; i < 2; i++) begin
      last_fall[i] = forced(i); last_rise[i] = forced(i);
      exp_first[i] = forced(i); exp_second[i] = forced(i);
    end
  endtask

  always @(posedge arst) force_async();

  always @(negedge clk) begin
    for (int i = 0; i < 3; i++)
      if (!(i < 2 && arst)) last_fall[i] = upd(last_fall[i], din);
  end

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (i < 2 && arst) continue;
      if (RISE_FIRST[i]) begin
        exp_first[i]  = upd(exp_first[i], last_rise[i]);
        exp_second[i] = upd(exp_second[i], last_fall[i]);
        last_rise[i]  = upd(last_rise[i], din);
      end else begin
        exp_first[i]  = upd(exp_first[i], last_fall[i]);
        exp_second[i] = upd(exp_second[i], din);
      end
    end
  end

  task automatic check_val(input string req, input string what,
                           input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    for (int i = 0; i < 3; i++) begin
      check_val(req, $sformatf("copy%0d first_o", i), act_first[i], exp_first[i]);
      check_val(req, $sformatf("copy%0d second_o", i), act_second[i], exp_second[i]);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) compare_all(tag);
  end

  // R11: nothing moves across a falling edge
  always @(negedge clk) begin
    #1;
    if (!done) compare_all("R11");
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // One clock period, entered at rising edge + 2 ns.
  task automatic cyc(input logic [7:0] fall_v, input logic [7:0] rise_v,
                     input logic e, input logic c, input logic s);
    en = e; sclr = c; sset = s; din = fall_v;
    #4;
    din = rise_v;
    #4;
  endtask

  initial begin
    #1;
    // R4 R5 R6: state before the first edge
    check_val("R4", "copy0 first_o at start", act_first[0], 8'h00);
    check_val("R5", "copy1 second_o at start", act_second[1], 8'hFF);
    check_val("R6", "copy2 first_o power-up", act_first[2], 8'hFF);
    check_val("R6", "copy2 second_o power-up", act_second[2], 8'hFF);
    #5;
    arst = 1'b0;
    tag = "R1 R2 R3";
    for (int k = 0; k < 8; k++)
      cyc(8'(8'h31 * k + 8'h0C), 8'(8'hA5 ^ (8'h17 * k)), 1'b1, 1'b0, 1'b0);
    tag = "R10";
    for (int k = 0; k < 3; k++) cyc(8'h5A + 8'(k), 8'hC3 - 8'(k), 1'b0, 1'b0, 1'b0);
    tag = "R1 R2 R3";
    for (int k = 0; k < 3; k++) cyc(8'h66 + 8'(k), 8'h99 + 8'(k), 1'b1, 1'b0, 1'b0);
    tag = "R7";
    cyc(8'h12, 8'h34, 1'b1, 1'b1, 1'b0);
    cyc(8'h56, 8'h78, 1'b0, 1'b1, 1'b0);
    tag = "R2 R3";
    for (int k = 0; k < 3; k++) cyc(8'h81 + 8'(k), 8'h42 + 8'(k), 1'b1, 1'b0, 1'b0);
    tag = "R8";
    cyc(8'h01, 8'h02, 1'b1, 1'b0, 1'b1);
    cyc(8'h03, 8'h04, 1'b0, 1'b0, 1'b1);
    tag = "R2 R3";
    for (int k = 0; k < 3; k++) cyc(8'hE0 + 8'(k), 8'h0F + 8'(k), 1'b1, 1'b0, 1'b0);
    tag = "R9 R10";
    cyc(8'h77, 8'h88, 1'b0, 1'b1, 1'b1);
    cyc(8'h99, 8'hAA, 1'b1, 1'b1, 1'b1);
    tag = "R1";
    for (int k = 0; k < 3; k++) cyc(8'h3C + 8'(k), 8'hD2 + 8'(k), 1'b1, 1'b0, 1'b0);
    // R4 R5 R6: async pulse mid-run with live data
    tag = "R4 R5 R6";
    arst = 1'b1;
    #1;
    check_val("R4", "copy0 first_o async", act_first[0], 8'h00);
    check_val("R5", "copy1 first_o async", act_first[1], 8'hFF);
    #7;
    cyc(8'h21, 8'h43, 1'b1, 1'b0, 1'b0);
    cyc(8'h65, 8'h87, 1'b1, 1'b0, 1'b0);
    arst = 1'b0;
    tag = "R2 R3";
    for (int k = 0; k < 5; k++)
      cyc(8'(8'h1D * k + 8'h40), 8'(8'h4B * k + 8'h07), 1'b1, 1'b0, 1'b0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired t=%0t", $time);
      summary();
      $finish;
    end
  end

endmodule